// File: doc/BRIEF.md
# Bimodal Branch Predictor with Misprediction Penalty

The block keeps a small table of 2-bit saturating counters. Each counter predicts whether a conditional branch at a given code address will be taken. The block is fed only with resolved branches. Each resolve strobe carries the branch address and the outcome that was actually taken. The block looks up the counter that the address selects and treats the counter's upper bit as the prediction. One cycle later it reports four things: the prediction it made, whether that prediction was wrong, how many stall cycles the miss costs, and a jump marker. Hazard logic further down the pipeline uses the jump marker to apply penalties tied to jumps.

The counter is trained from the outcome. A taken branch moves it up and a not-taken branch moves it down, and it saturates at both ends. The write lands in the cycle after the strobe. A resolve of the same entry in that cycle reads the new value through a bypass, so back-to-back branches at one address see each other's training. Target prediction and pipeline flushing are handled elsewhere.

Top module: `bimodal_predictor`

## Requirements
- R1: The entry used is `(pc & (TABLE_BYTES-1)) >> 1`, which is `pc[IDX_W:1]` with `TABLE_BYTES = 2^(IDX_W+1)`. Address bit 0 and all bits at or above bit `IDX_W+1` have no effect on the entry chosen.
- R2: `pred_taken` is 1 exactly when the selected counter holds 2 or 3 (its bit 1 is set).
- R3: `mispredict` is 1 when `pred_taken` differs from the resolved outcome. `penalty` is then `MISS_PENALTY` (default 2); it is 0 on a correct prediction.
- R4: A taken resolve adds one to its counter. The counter stays at 3 once it is there.
- R5: A not-taken resolve subtracts one from its counter. The counter stays at 0 once it is there.
- R6: On every valid resolve, `jump` equals the resolved outcome, so a taken branch is reported as a jump.
- R7: A synchronous reset clears every counter to 0 (strongly not taken) and clears all outputs. The first resolve of any entry after reset predicts not taken.
- R8: Results appear with `out_valid` exactly one clock after `resolve_valid`. In a cycle without a result, `mispredict`, `jump` and `penalty` are 0 and no counter changes.
- R9: A resolve of an entry in the cycle directly after a resolve of the same entry sees the already-updated counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| resolve_valid | input | 1 | A branch has resolved this cycle |
| resolve_pc | input | PC_W | Address of the resolved branch |
| resolve_taken | input | 1 | Actual outcome, 1 = taken |
| out_valid | output | 1 | Result for the previous cycle's resolve |
| pred_taken | output | 1 | Prediction the table gave |
| mispredict | output | 1 | Prediction differed from the outcome |
| penalty | output | PEN_W | Stall cycles caused by this branch |
| jump | output | 1 | Taken branch marker for hazard logic |

## Verification
Two things can fall in the same cycle: the pending write-back of a counter and a fresh lookup of that same counter. This happens whenever resolves of one entry arrive back to back. The bench provokes it with directed runs of consecutive strobes to a single address, including its aliases that differ in bit 0 or in the upper bits. It also uses a long pseudo-random stream of mostly back-to-back resolves to a small 8-entry table. Each prediction is compared against a bench-side counter model that is updated immediately, so a missing or stale bypass shows up as a wrong prediction or a wrong penalty.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN = 2'd0;
  localparam ctr_t CTR_MAX = 2'd3;

  // Saturating step of a 2-bit counter toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_predicts_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 5
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  // Halfword-aligned address: drop bit 0, keep IDX_W bits above it.
  assign idx = pc[IDX_W:1];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[0], pc[PC_W-1:IDX_W+1]};

  initial begin
    AST_PC_WIDE: assert (PC_W > IDX_W + 1) else $error("PC_W too small"); // R1
  end
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ctr_t             wr_val
);
  ctr_t cells [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        cells[g] <= CTR_MIN;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        cells[g] <= wr_val;
    end
  end

  // Pending write-back is forwarded to a same-cycle read of the same entry.
  logic hit_pending;
  assign hit_pending = wr_en && (wr_idx == rd_idx);
  assign rd_cnt      = hit_pending ? wr_val : cells[rd_idx];

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (cells[rd_idx] == CTR_MIN)); // R7

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cells[$past(wr_idx)] == $past(wr_val))); // R9

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve
  import bp_pkg::*;
#(
  parameter int IDX_W        = 5,
  parameter int MISS_PENALTY = 2,
  parameter int PEN_W        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  logic             in_taken,
  input  ctr_t             cur_cnt,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output ctr_t             wr_val,
  output logic             out_valid,
  output logic             out_pred,
  output logic             out_miss,
  output logic [PEN_W-1:0] out_pen,
  output logic             out_jump
);
  localparam logic [PEN_W-1:0] PEN_MISS = PEN_W'(MISS_PENALTY);

  logic guess;
  logic wrong;
  assign guess = ctr_predicts_taken(cur_cnt);
  assign wrong = in_valid && (guess != in_taken);

  // Deferred counter write-back.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en  <= 1'b0;
      wr_idx <= '0;
      wr_val <= CTR_MIN;
    end else begin
      wr_en  <= in_valid;
      wr_idx <= in_idx;
      wr_val <= ctr_step(cur_cnt, in_taken);
    end
  end

  // Registered report.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pred  <= 1'b0;
      out_miss  <= 1'b0;
      out_pen   <= '0;
      out_jump  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_pred  <= in_valid && guess;
      out_miss  <= wrong;
      out_pen   <= wrong ? PEN_MISS : '0;
      out_jump  <= in_valid && in_taken;
    end
  end

  AST_SAT_UP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_taken) |=>
      (wr_val == (($past(cur_cnt) == CTR_MAX) ? CTR_MAX : $past(cur_cnt) + 2'd1))); // R4

  AST_SAT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_taken) |=>
      (wr_val == (($past(cur_cnt) == CTR_MIN) ? CTR_MIN : $past(cur_cnt) - 2'd1))); // R5

  AST_PRED_BIT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_pred == ($past(cur_cnt) >= 2'd2))); // R2

endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor
  import bp_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int TABLE_BYTES  = 64,
  parameter int MISS_PENALTY = 2,
  parameter int PEN_W        = $clog2(MISS_PENALTY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resolve_valid,
  input  logic [PC_W-1:0]  resolve_pc,
  input  logic             resolve_taken,
  output logic             out_valid,
  output logic             pred_taken,
  output logic             mispredict,
  output logic [PEN_W-1:0] penalty,
  output logic             jump
);
  localparam int ENTRIES = TABLE_BYTES / 2;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic [IDX_W-1:0] lookup_idx;
  ctr_t             lookup_cnt;
  logic             wb_en;
  logic [IDX_W-1:0] wb_idx;
  ctr_t             wb_val;

  bp_index #(
    .PC_W (PC_W),
    .IDX_W(IDX_W)
  ) u_index (
    .pc (resolve_pc),
    .idx(lookup_idx)
  );

  bp_counter_table #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
  ) u_table (
    .clk   (clk),
    .rst   (rst),
    .rd_idx(lookup_idx),
    .rd_cnt(lookup_cnt),
    .wr_en (wb_en),
    .wr_idx(wb_idx),
    .wr_val(wb_val)
  );

  bp_resolve #(
    .IDX_W       (IDX_W),
    .MISS_PENALTY(MISS_PENALTY),
    .PEN_W       (PEN_W)
  ) u_resolve (
    .clk      (clk),
    .rst      (rst),
    .in_valid (resolve_valid),
    .in_idx   (lookup_idx),
    .in_taken (resolve_taken),
    .cur_cnt  (lookup_cnt),
    .wr_en    (wb_en),
    .wr_idx   (wb_idx),
    .wr_val   (wb_val),
    .out_valid(out_valid),
    .out_pred (pred_taken),
    .out_miss (mispredict),
    .out_pen  (penalty),
    .out_jump (jump)
  );

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resolve_valid |=> out_valid); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!mispredict && !jump && (penalty == '0))); // R8

  AST_MISS_REL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (mispredict == (pred_taken != jump))); // R3

  AST_PEN_VALUE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (penalty == (mispredict ? PEN_W'(MISS_PENALTY) : '0))); // R3

  AST_JUMP_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    resolve_valid |=> (jump == $past(resolve_taken))); // R6

endmodule

// File: tb/test_bimodal_predictor.sv
module test_bimodal_predictor;
  localparam int PC_W = 8;
  localparam int TBYTES = 16;
  localparam int ENT = TBYTES / 2;
  localparam int MPEN = 2;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rv = 1'b0;
  logic rt = 1'b0;
  logic [PC_W-1:0] rpc = '0;
  logic o_valid, o_pred, o_miss, o_jump;
  logic [PW-1:0] o_pen;

  always #2 clk = ~clk;

  bimodal_predictor #(
    .PC_W(PC_W), .TABLE_BYTES(TBYTES), .MISS_PENALTY(MPEN), .PEN_W(PW)
  ) i_bimodal_predictor (
    .clk(clk), .rst(rst), .resolve_valid(rv), .resolve_pc(rpc),
    .resolve_taken(rt), .out_valid(o_valid), .pred_taken(o_pred),
    .mispredict(o_miss), .penalty(o_pen), .jump(o_jump)
  );

  int tests = 0;
  int fails = 0;
  int model [ENT];
  logic e_valid = 1'b0;
  logic e_pred = 1'b0;
  logic e_jump = 1'b0;
  string e_tag = "R2";

  task automatic check1(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Check the result of the previous step, then drive a new one.
  task automatic step(logic v, logic [PC_W-1:0] pc, logic t, string tag);
    int idx;
    @(negedge clk);
    check1("R8 valid", int'(o_valid), int'(e_valid));
    if (e_valid) begin
      check1(e_tag, int'(o_pred), int'(e_pred));
      check1("R3 mispredict", int'(o_miss), int'(e_pred != e_jump));
      check1("R3 penalty", int'(o_pen), (e_pred != e_jump) ? MPEN : 0);
      check1("R6 jump", int'(o_jump), int'(e_jump));
    end else begin
      check1("R8 idle mispredict", int'(o_miss), 0);
      check1("R8 idle penalty", int'(o_pen), 0);
      check1("R8 idle jump", int'(o_jump), 0);
    end
    e_valid = v;
    if (v) begin
      idx = (int'(pc) & (TBYTES - 1)) >> 1;
      e_pred = (model[idx] >= 2);
      e_jump = t;
      e_tag = tag;
      if (t) model[idx] = (model[idx] == 3) ? 3 : model[idx] + 1;
      else   model[idx] = (model[idx] == 0) ? 0 : model[idx] - 1;
    end
    rv = v;
    rpc = pc;
    rt = t;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < ENT; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check1("R7 reset valid", int'(o_valid), 0);
    check1("R7 reset mispredict", int'(o_miss), 0);
    check1("R7 reset penalty", int'(o_pen), 0);
    check1("R7 reset jump", int'(o_jump), 0);
    rst = 1'b0;

    // R7: every entry starts strongly not taken
    for (int e = 0; e < ENT; e++) step(1'b1, PC_W'(e * 2), 1'b0, "R7 initial prediction");

    // R1 / R9: train entry 2 back to back, then probe through aliases
    for (int k = 0; k < 3; k++) step(1'b1, 8'h04, 1'b1, "R9 bypass prediction");
    step(1'b1, 8'h35, 1'b1, "R1 alias bit0+upper");
    step(1'b1, 8'h95, 1'b0, "R1 alias upper");
    step(1'b1, 8'h06, 1'b0, "R1 neighbour untouched");
    step(1'b0, 8'h04, 1'b0, "R8");
    step(1'b1, 8'h05, 1'b1, "R1 alias after gap");

    // R4: saturate entry 5 high, one not-taken keeps it predicting taken
    for (int k = 0; k < 6; k++) step(1'b1, 8'h0A, 1'b1, "R4 rising");
    step(1'b1, 8'h0B, 1'b0, "R4 at max");
    step(1'b1, 8'h0A, 1'b1, "R4 after saturation");

    // R5: saturate entry 6 low, two takens needed to predict taken
    for (int k = 0; k < 5; k++) step(1'b1, 8'h0C, 1'b0, "R5 falling");
    step(1'b1, 8'h0C, 1'b1, "R5 at min");
    step(1'b1, 8'h0D, 1'b1, "R5 one up");
    step(1'b1, 8'hEC, 1'b0, "R5 two up");

    // R8: idle cycles change nothing
    for (int k = 0; k < 4; k++) step(1'b0, PC_W'(k * 2), 1'b1, "R8");
    for (int e = 0; e < ENT; e++) step(1'b1, PC_W'(e * 2 + 1), 1'b1, "R8 state after idle");

    // Pseudo-random mix, mostly back to back
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[15:8] & ((n % 3 == 0) ? 8'hFF : 8'hF3),
           lfsr[4] | (lfsr[5] & lfsr[6]), "R2 random");
    end
    step(1'b0, '0, 1'b0, "R8");
    step(1'b0, '0, 1'b0, "R8");
    finish_run();
  end
endmodule